// File: doc/BRIEF.md
# Prescaled Shared PWM Timebase

This block is the one up-counter that every channel of a multi-channel PWM timer compares against. A power-of-two prescaler divides the input clock. The counter steps from zero up to an active modulo value and then returns to zero. Each return to zero raises a one-cycle period-start strobe. The count value, the strobe and a running flag go to the channel blocks.

Software reaches the block through a simple register port. Writes select one of three locations, and a combinational read port returns any of them. The control word holds the prescale exponent, the counter mode and a center-aligned flag. The center-aligned flag is stored and read back but has no effect, since only edge-aligned up-counting is built. The modulo word is double-buffered. A write lands at once while the counter is stopped. While the counter runs, the written value waits until the current period ends, so a running period is never cut short. Reading the modulo location always returns the value in force, so software can poll it to confirm that a pending write has taken effect.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the control word reads 0, the modulo reads 0xFFFF, the count is 0, and both the running flag and the strobe are low.
- R2: The address map is: 0 for control, 1 for modulo, 2 for count (read-only), and 3 always reads 0. In the control word, bits [2:0] hold the prescale exponent PS, bits [4:3] hold the mode, and bit 5 holds the center-aligned flag. Control bits above 5 read as 0.
- R3: The counter runs, and the running flag is high, whenever the mode is not 00. Mode 00 stops the counter. Mode 01 steps on every prescaled tick, and modes 10 and 11 behave the same way.
- R4: While running with modulo M and prescale PS, the count goes 0, 1, …, M and then 0 again, so one period lasts (M+1)·2^PS clocks.
- R5: The strobe is high for exactly one cycle, namely the cycle in which the count has just returned to 0. With M = 0 and PS = 0 it stays high continuously.
- R6: A modulo write while the counter is stopped becomes the active value on the next clock, and reads back at once.
- R7: A modulo write while the counter runs is held pending. The modulo location still reads the old value, and the current period runs to the old limit. The new value takes effect for the period that starts at the next wrap.
- R8: A pending modulo value that has not yet been applied becomes active once the counter is stopped.
- R9: Writing mode 00 freezes the count. Writing a non-zero mode while stopped clears the count to 0 on that clock edge. The first step to 1 comes 2^PS clocks later.
- R10: Reading location 2 returns the same value as the count output.
- R11: The center-aligned flag does not change the counting sequence or the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the location at wr_addr |
| wr_addr | input | 2 | Write location select |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read location select |
| rd_data | output | DATA_W | Read data (combinational) |
| count_o | output | MOD_W | Live counter value |
| period_start_o | output | 1 | One-cycle strobe when the count wraps to 0 |
| running_o | output | 1 | Counter mode is non-zero |

## Verification
A table of prescale and modulo pairs is tried, from the minimum setting (modulo 0, prescale 0) up to the largest divider. Each pair is checked for strobe spacing, for the count being 0 at the strobe, and for the delay to the first step after a restart. These checks tell apart errors in the prescaler mask from errors in the wrap comparison. Separate directed sequences write the modulo while the counter runs and while it is stopped, and they stop the counter with a write still pending. These sequences separate immediate loading from boundary loading. They also show whether a running period runs to its old limit. A run with mode 10 and a run with the center flag set confirm that both count like mode 01.

// File: rtl/ptb_pkg.sv
package ptb_pkg;

    localparam int PS_W = 3;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MOD  = 2'd1,
        ADDR_CNT  = 2'd2,
        ADDR_NONE = 2'd3
    } ptb_addr_e;

    typedef enum logic [1:0] {
        MODE_STOP  = 2'd0,
        MODE_EVERY = 2'd1,
        MODE_ALT2  = 2'd2,
        MODE_ALT3  = 2'd3
    } ptb_mode_e;

    // packed order gives center at bit 5, mode at [4:3], prescale at [2:0]
    typedef struct packed {
        logic              center;
        ptb_mode_e         mode;
        logic [PS_W-1:0]   ps;
    } ptb_ctrl_t;

endpackage

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [DIV_W:0]   one_hot;
    logic [DIV_W-1:0] mask;

    always_comb begin
        one_hot = (DIV_W+1)'(1) << ps;
        mask    = one_hot[DIV_W-1:0] - DIV_W'(1);
        tick    = run && ((st_q.div & mask) == mask);
        st_d    = st_q;
        if (run) begin
            st_d.div = st_q.div + DIV_W'(1);
        end else begin
            st_d.div = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [MOD_W-1:0] mod_active,
    output logic [MOD_W-1:0] count,
    output logic             wrap,
    output logic             period_start
);
    typedef struct packed {
        logic [MOD_W-1:0] cnt;
        logic             pstart;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pstart = 1'b0;
        wrap        = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= mod_active) begin
                st_d.cnt    = '0;
                st_d.pstart = 1'b1;
                wrap        = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + MOD_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count        = st_q.cnt;
    assign period_start = st_q.pstart;
endmodule

// File: rtl/ptb_modbuf.sv
module ptb_modbuf #(
    parameter int MOD_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr,
    input  logic [MOD_W-1:0] wdata,
    input  logic             wrap,
    output logic [MOD_W-1:0] active
);
    typedef struct packed {
        logic [MOD_W-1:0] active;
        logic [MOD_W-1:0] pend;
        logic             pend_v;
    } mb_st_t;

    mb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // apply a waiting value at a period boundary or once stopped
        if (st_q.pend_v && (wrap || !run)) begin
            st_d.active = st_q.pend;
            st_d.pend_v = 1'b0;
        end
        if (wr) begin
            if (!run) begin
                st_d.active = wdata;
                st_d.pend_v = 1'b0;
            end else begin
                st_d.pend   = wdata;
                st_d.pend_v = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= '1;
            st_q.pend   <= '0;
            st_q.pend_v <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import ptb_pkg::*;
#(
    parameter int MOD_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [MOD_W-1:0]  count_o,
    output logic              period_start_o,
    output logic              running_o
);
    localparam int CTRL_W = $bits(ptb_ctrl_t);

    typedef struct packed {
        ptb_ctrl_t ctrl;
    } top_st_t;

    top_st_t          st_d, st_q;
    ptb_ctrl_t        wr_ctrl_val;
    logic             wr_ctrl, wr_mod, restart, tick, wrap;
    logic [MOD_W-1:0] mod_active;

    always_comb begin
        wr_ctrl     = wr_en && (ptb_addr_e'(wr_addr) == ADDR_CTRL);
        wr_mod      = wr_en && (ptb_addr_e'(wr_addr) == ADDR_MOD);
        wr_ctrl_val = ptb_ctrl_t'(wr_data[CTRL_W-1:0]);
        running_o   = (st_q.ctrl.mode != MODE_STOP);
        restart     = wr_ctrl && !running_o && (wr_ctrl_val.mode != MODE_STOP);
        st_d        = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = wr_ctrl_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (ptb_addr_e'(rd_addr))
            ADDR_CTRL: rd_data = DATA_W'(st_q.ctrl);
            ADDR_MOD:  rd_data = DATA_W'(mod_active);
            ADDR_CNT:  rd_data = DATA_W'(count_o);
            default:   rd_data = '0;
        endcase
    end

    ptb_prescaler #(.PS_W(PS_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running_o),
        .ps    (st_q.ctrl.ps),
        .tick  (tick)
    );

    ptb_modbuf #(.MOD_W(MOD_W)) u_mod (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (running_o),
        .wr     (wr_mod),
        .wdata  (wr_data[MOD_W-1:0]),
        .wrap   (wrap),
        .active (mod_active)
    );

    ptb_counter #(.MOD_W(MOD_W)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .restart      (restart),
        .mod_active   (mod_active),
        .count        (count_o),
        .wrap         (wrap),
        .period_start (period_start_o)
    );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
    parameter int MOD_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             period_start,
    input logic [MOD_W-1:0] count,
    input logic [MOD_W-1:0] mod_active
);
    AST_CNT_WITHIN_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (count <= mod_active)); // R4

    AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (count == '0)); // R5

    AST_STROBE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> $past(running)); // R3

    AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && $past(!running)) |-> $stable(count)); // R9

    AST_MOD_HELD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !period_start) |-> $stable(mod_active)); // R7
endmodule

bind pwm_timebase ptb_checker #(.MOD_W(MOD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .running      (running_o),
    .period_start (period_start_o),
    .count        (count_o),
    .mod_active   (mod_active)
);

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
    localparam int MOD_W  = 16;
    localparam int DATA_W = 16;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_MOD  = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;
    localparam logic [1:0] A_NONE = 2'd3;
    localparam int NVEC = 7;
    // {prescale[34:32], modulo[31:16], expected period in clocks[15:0]}
    localparam logic [34:0] VEC [NVEC] = '{
        {3'd0, 16'd3,  16'd4},
        {3'd1, 16'd2,  16'd6},
        {3'd2, 16'd5,  16'd24},
        {3'd3, 16'd0,  16'd8},
        {3'd0, 16'd0,  16'd1},
        {3'd7, 16'd1,  16'd256},
        {3'd0, 16'd15, 16'd16}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0]        rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [MOD_W-1:0]  count_o;
    logic              period_start_o;
    logic              running_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    pwm_timebase #(.MOD_W(MOD_W), .DATA_W(DATA_W)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_addr        (wr_addr),
        .wr_data        (wr_data),
        .rd_addr        (rd_addr),
        .rd_data        (rd_data),
        .count_o        (count_o),
        .period_start_o (period_start_o),
        .running_o      (running_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_strobe();
        for (int i = 0; i < 3000 && !period_start_o; i++) @(negedge clk);
    endtask

    task automatic measure(input string tag, output int per);
        wait_strobe();
        chk({tag, " R5 count zero at strobe"}, 32'(count_o), 0);
        per = 0;
        do begin
            @(negedge clk);
            per++;
        end while (!period_start_o && per < 3000);
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        int per;
        int peak;
        logic [MOD_W-1:0] held;

        repeat (3) @(negedge clk);
        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", 32'(v), 0);
        rd(A_MOD, v);  chk("R1 modulo", 32'(v), 32'hFFFF);
        chk("R1 count", 32'(count_o), 0);
        chk("R1 running", 32'(running_o), 0);
        chk("R1 strobe", 32'(period_start_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: period, restart delay, strobe width
        for (int k = 0; k < NVEC; k++) begin
            logic [2:0]  ps;
            logic [15:0] md, exp_per;
            {ps, md, exp_per} = VEC[k];
            wr(A_CTRL, 16'h0000);
            wr(A_MOD, md);
            wr(A_CTRL, {11'd0, 2'b01, ps});
            chk("R9 count zero after restart", 32'(count_o), 0);
            if (md != 0) begin
                repeat ((1 << ps) - 1) @(negedge clk);
                chk("R9 still zero before first tick", 32'(count_o), 0);
                @(negedge clk);
                chk("R9 first step to one", 32'(count_o), 1);
            end
            measure("vec", per);
            chk("R4 period", 32'(per), 32'(exp_per));
            if (exp_per > 1) begin
                @(negedge clk);
                chk("R5 strobe one cycle", 32'(period_start_o), 0);
            end else begin
                chk("R5 strobe constant at minimum", 32'(period_start_o), 1);
            end
        end

        // R2 control readback and reserved bits; R3 mode 11 runs
        wr(A_CTRL, 16'h0000);
        wr(A_CTRL, 16'hFF3D);
        rd(A_CTRL, v); chk("R2 ctrl readback", 32'(v), 32'h3D);
        chk("R3 mode 11 running", 32'(running_o), 1);
        rd(A_NONE, v); chk("R2 location 3 zero", 32'(v), 0);

        // R11 center flag ignored
        wr(A_CTRL, 16'h0000);
        wr(A_MOD, 16'd4);
        wr(A_CTRL, 16'h0028);
        measure("center", per);
        chk("R11 period with center flag", 32'(per), 5);

        // R6 immediate load; R7 pending load while running
        wr(A_CTRL, 16'h0000);
        wr(A_MOD, 16'd9);
        rd(A_MOD, v); chk("R6 immediate modulo", 32'(v), 9);
        wr(A_CTRL, 16'h0008);
        wait_strobe();
        repeat (2) @(negedge clk);
        wr(A_MOD, 16'd3);
        rd(A_MOD, v); chk("R7 readback still old", 32'(v), 9);
        rd(A_CNT, v); chk("R10 count readback", 32'(v), 32'(count_o));
        peak = 0;
        while (!period_start_o && peak < 1000) begin
            if (int'(count_o) > peak) peak = int'(count_o);
            @(negedge clk);
        end
        chk("R7 period not shortened", 32'(peak), 9);
        rd(A_MOD, v); chk("R7 applied at wrap", 32'(v), 3);
        per = 0;
        do begin @(negedge clk); per++; end while (!period_start_o && per < 1000);
        chk("R7 new period", 32'(per), 4);

        // R9 stop freezes count; R3 stopped flag
        wr(A_CTRL, 16'h0000);
        held = count_o;
        repeat (5) @(negedge clk);
        chk("R9 count frozen", 32'(count_o), 32'(held));
        chk("R3 mode 00 stopped", 32'(running_o), 0);

        // R8 pending applied once stopped
        wr(A_MOD, 16'd200);
        wr(A_CTRL, 16'h0008);
        wr(A_MOD, 16'd12);
        rd(A_MOD, v); chk("R8 pending not yet active", 32'(v), 200);
        wr(A_CTRL, 16'h0000);
        @(negedge clk);
        rd(A_MOD, v); chk("R8 pending applied on stop", 32'(v), 12);

        // R3 mode 10 also counts
        wr(A_CTRL, 16'h0010);
        chk("R3 mode 10 running", 32'(running_o), 1);
        repeat (3) @(negedge clk);
        chk("R3 mode 10 advances", 32'(count_o), 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule